// File: doc/BRIEF.md
# Stack-Addressed Floating-Point Register File

This block holds eight 80-bit operand registers for a floating-point unit. Software never names a register by its physical slot. A 3-bit top pointer moves with each load and store. An operand is named by its distance from the top, so st(0) is always the top entry and st(i) lives in physical slot (top + i) mod 8. Each slot has a tag bit that says whether it holds a value or is empty.

Commands arrive on one command port. A push loads a new value, a pop returns st(0) and frees it, an exchange swaps st(0) with st(i), and two read forms supply the operands of a dyadic operation. The arithmetic happens outside this block. Its result comes back on a separate write-back port and always lands in st(0), which acts as the accumulator. The block flags a push onto an occupied slot as an overflow. It flags any use of an empty slot as an operand as an underflow. Either fault leaves the stack exactly as it was.

Top module: `fpstk_regfile`

## Requirements
- R1: After a synchronous reset, top_o is 0, tag_o is all zeros (every slot empty), and stack_overflow, stack_underflow and out_valid are 0.
- R2: cmd_op encodes 0 as no operation, 1 as push, 2 as pop, 3 as exchange, 4 as the implicit read and 5 as the explicit read; the codes 6 and 7 act as no operation. On a push whose target slot is empty, the target slot is (top - 1) mod 8, so top 0 becomes 7. The target slot receives push_data and its tag is set, and the new top is visible after one clock edge.
- R3: A push whose target slot is already valid raises stack_overflow for exactly one cycle. It leaves top_o, tag_o and every register's contents unchanged, and out_valid stays 0.
- R4: A pop with a valid st(0) presents the old st(0) on opa_data with out_valid high for one cycle. The same edge clears that slot's tag and moves top to (top + 1) mod 8.
- R5: An underflow is a pop of an empty st(0), an exchange with either operand empty, or a read with either operand empty. It raises stack_underflow for one cycle with out_valid 0, and it leaves top, tags and contents unchanged.
- R6: The implicit read (code 4) ignores cmd_idx. When both operands are valid it gives st(0) on opa_data and st(1) on opb_data, with out_valid high, one cycle after the command.
- R7: The explicit read (code 5) gives st(0) on opa_data and st(cmd_idx) on opb_data, with out_valid high, one cycle after the command. An index of 0 gives st(0) on both.
- R8: An exchange with both operands valid swaps the contents of st(0) and st(cmd_idx) in a single clock edge, with top and tags unchanged. An index of 0 leaves the contents unchanged.
- R9: While wb_en is high, wb_data is written into st(0) and that slot's tag is set. Any command in the same cycle is ignored: top does not move, and no flag or out_valid is raised.
- R10: Bit p of tag_o is the tag of physical slot p. Operand st(i) always refers to physical slot (top_o + i) mod 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | Command code (see R2) |
| cmd_idx | input | 3 | Relative operand index i for exchange and explicit read |
| push_data | input | 80 | Value loaded by a push |
| wb_en | input | 1 | Write a result into st(0) |
| wb_data | input | 80 | Result value for st(0) |
| opa_data | output | 80 | First operand (st(0)) or popped value |
| opb_data | output | 80 | Second operand |
| out_valid | output | 1 | opa_data/opb_data carry a fresh read or pop result |
| stack_overflow | output | 1 | One-cycle pulse: push onto a valid slot |
| stack_underflow | output | 1 | One-cycle pulse: empty operand used |
| top_o | output | 3 | Current top pointer |
| tag_o | output | 8 | Valid tag of each physical slot |

## Verification
Every result of this block is due one clock edge after its command or write-back: the new top and tags, both fault pulses, out_valid and the two operand buses. The bench presents each stimulus on a falling edge and samples on the next falling edge, halfway after the single rising edge that takes effect. It compares the sample against a bench model that it steps at the same moment. Ignored commands (faults, and commands beside a write-back) are checked in two ways. The sampled top and tags must be unchanged in that cycle, and the contents are read back later through the read commands.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_PUSH = 3'd1,
    OP_POP  = 3'd2,
    OP_XCHG = 3'd3,
    OP_RD01 = 3'd4,
    OP_RD0I = 3'd5
  } stk_op_e;
endpackage

// File: rtl/fpstk_ptr.sv
module fpstk_ptr #(
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dec,
  input  logic             inc,
  output logic [PTR_W-1:0] top
);
  always_ff @(posedge clk) begin
    if (rst)      top <= '0;
    else if (dec) top <= top - 1'b1;
    else if (inc) top <= top + 1'b1;
  end
endmodule

// File: rtl/fpstk_tags.sv
module fpstk_tags #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [PTR_W-1:0] set_addr,
  input  logic             clr_en,
  input  logic [PTR_W-1:0] clr_addr,
  output logic [DEPTH-1:0] tags
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_tag
    always_ff @(posedge clk) begin
      if (rst)
        tags[g] <= 1'b0;
      else if (set_en && set_addr == PTR_W'(g))
        tags[g] <= 1'b1;
      else if (clr_en && clr_addr == PTR_W'(g))
        tags[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/fpstk_store.sv
module fpstk_store #(
  parameter int DATA_W = 80,
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wa_en,
  input  logic [PTR_W-1:0]  wa_addr,
  input  logic [DATA_W-1:0] wa_data,
  input  logic              wx_en,
  input  logic [PTR_W-1:0]  wx_addr,
  input  logic [DATA_W-1:0] wx_data,
  input  logic [PTR_W-1:0]  ra_addr,
  input  logic [PTR_W-1:0]  rb_addr,
  output logic [DATA_W-1:0] ra_data,
  output logic [DATA_W-1:0] rb_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wa_en) mem[wa_addr] <= wa_data;
    if (wx_en) mem[wx_addr] <= wx_data;
  end

  assign ra_data = mem[ra_addr];
  assign rb_data = mem[rb_addr];
endmodule

// File: rtl/fpstk_regfile.sv
module fpstk_regfile
  import fpstk_pkg::*;
#(
  parameter int DATA_W = 80,
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [PTR_W-1:0]  cmd_idx,
  input  logic [DATA_W-1:0] push_data,
  input  logic              wb_en,
  input  logic [DATA_W-1:0] wb_data,
  output logic [DATA_W-1:0] opa_data,
  output logic [DATA_W-1:0] opb_data,
  output logic              out_valid,
  output logic              stack_overflow,
  output logic              stack_underflow,
  output logic [PTR_W-1:0]  top_o,
  output logic [DEPTH-1:0]  tag_o
);
  stk_op_e           op;
  logic [PTR_W-1:0]  top, top_m1, top_p1, top_pi, rb_sel;
  logic [DEPTH-1:0]  tags;
  logic [DATA_W-1:0] rd_a, rd_b;
  logic              push_ok, pop_ok, xchg_ok, rd_ok, ovf_d, unf_d;
  logic              wa_en;
  logic [PTR_W-1:0]  wa_addr;
  logic [DATA_W-1:0] wa_data;

  assign op     = stk_op_e'(cmd_op);
  assign top_m1 = top - 1'b1;
  assign top_p1 = top + 1'b1;
  assign top_pi = top + cmd_idx;
  assign rb_sel = (op == OP_RD01) ? top_p1 : top_pi;

  always_comb begin
    push_ok = 1'b0;
    pop_ok  = 1'b0;
    xchg_ok = 1'b0;
    rd_ok   = 1'b0;
    ovf_d   = 1'b0;
    unf_d   = 1'b0;
    if (cmd_valid && !wb_en) begin
      case (op)
        OP_PUSH: begin
          push_ok = !tags[top_m1];
          ovf_d   = tags[top_m1];
        end
        OP_POP: begin
          pop_ok = tags[top];
          unf_d  = !tags[top];
        end
        OP_XCHG: begin
          xchg_ok = tags[top] && tags[top_pi];
          unf_d   = !(tags[top] && tags[top_pi]);
        end
        OP_RD01, OP_RD0I: begin
          rd_ok = tags[top] && tags[rb_sel];
          unf_d = !(tags[top] && tags[rb_sel]);
        end
        default: ;
      endcase
    end
  end

  assign wa_en   = push_ok || xchg_ok || wb_en;
  assign wa_addr = push_ok ? top_m1 : top;
  assign wa_data = wb_en ? wb_data : (push_ok ? push_data : rd_b);

  fpstk_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk (clk),
    .rst (rst),
    .dec (push_ok),
    .inc (pop_ok),
    .top (top)
  );

  fpstk_tags #(.DEPTH(DEPTH)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .set_en   (push_ok || wb_en),
    .set_addr (push_ok ? top_m1 : top),
    .clr_en   (pop_ok),
    .clr_addr (top),
    .tags     (tags)
  );

  fpstk_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .wa_en   (wa_en),
    .wa_addr (wa_addr),
    .wa_data (wa_data),
    .wx_en   (xchg_ok),
    .wx_addr (top_pi),
    .wx_data (rd_a),
    .ra_addr (top),
    .rb_addr (rb_sel),
    .ra_data (rd_a),
    .rb_data (rd_b)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      opa_data        <= '0;
      opb_data        <= '0;
      out_valid       <= 1'b0;
      stack_overflow  <= 1'b0;
      stack_underflow <= 1'b0;
    end else begin
      out_valid       <= pop_ok || rd_ok;
      stack_overflow  <= ovf_d;
      stack_underflow <= unf_d;
      if (pop_ok || rd_ok) opa_data <= rd_a;
      if (rd_ok)           opb_data <= rd_b;
    end
  end

  assign top_o = top;
  assign tag_o = tags;
endmodule

// File: rtl/fpstk_chk.sv
module fpstk_chk
  import fpstk_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic [2:0]       cmd_op,
  input logic             wb_en,
  input logic             out_valid,
  input logic             stack_overflow,
  input logic             stack_underflow,
  input logic [PTR_W-1:0] top_o,
  input logic [DEPTH-1:0] tag_o
);
  logic is_push, is_pop, is_xchg;
  assign is_push = cmd_valid && !wb_en && cmd_op == OP_PUSH;
  assign is_pop  = cmd_valid && !wb_en && cmd_op == OP_POP;
  assign is_xchg = cmd_valid && !wb_en && cmd_op == OP_XCHG;

  AST_PUSH_TOP: assert property (@(posedge clk) disable iff (rst)
    is_push |=> (stack_overflow || (top_o == PTR_W'($past(top_o) - 1'b1) && tag_o[top_o]))); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    stack_overflow |-> ($stable(top_o) && $stable(tag_o) && !out_valid)); // R3
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (rst)
    stack_overflow |-> $past(is_push)); // R3
  AST_POP_TOP: assert property (@(posedge clk) disable iff (rst)
    is_pop |=> (stack_underflow || (top_o == PTR_W'($past(top_o) + 1'b1) && !tag_o[$past(top_o)] && out_valid))); // R4
  AST_UNF_QUIET: assert property (@(posedge clk) disable iff (rst)
    stack_underflow |-> (!out_valid && $stable(top_o) && $stable(tag_o))); // R5
  AST_XCHG_KEEP: assert property (@(posedge clk) disable iff (rst)
    is_xchg |=> ($stable(top_o) && $stable(tag_o))); // R8
  AST_WB_VALID: assert property (@(posedge clk) disable iff (rst)
    wb_en |=> ($stable(top_o) && tag_o[top_o] && !stack_overflow && !stack_underflow && !out_valid)); // R9
endmodule

bind fpstk_regfile fpstk_chk #(.DEPTH(DEPTH)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .cmd_valid       (cmd_valid),
  .cmd_op          (cmd_op),
  .wb_en           (wb_en),
  .out_valid       (out_valid),
  .stack_overflow  (stack_overflow),
  .stack_underflow (stack_underflow),
  .top_o           (top_o),
  .tag_o           (tag_o)
);

// File: tb/sim_fpstk_regfile.sv
`timescale 1ns/1ps
module sim_fpstk_regfile;
  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [2:0]  cmd_idx;
  logic [79:0] push_data;
  logic        wb_en;
  logic [79:0] wb_data;
  logic [79:0] opa_data, opb_data;
  logic        out_valid, stack_overflow, stack_underflow;
  logic [2:0]  top_o;
  logic [7:0]  tag_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [79:0] m_mem [8];
  logic [7:0]  m_tag;
  logic [2:0]  m_top;

  fpstk_regfile u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
    .push_data(push_data), .wb_en(wb_en), .wb_data(wb_data),
    .opa_data(opa_data), .opb_data(opb_data), .out_valid(out_valid),
    .stack_overflow(stack_overflow), .stack_underflow(stack_underflow),
    .top_o(top_o), .tag_o(tag_o)
  );

  always #2.5 clk = ~clk;

  function automatic logic [79:0] rnd80();
    return {$urandom(), $urandom(), 16'($urandom())};
  endfunction

  function automatic logic [2:0] slot(input logic [2:0] t, input logic [2:0] i);
    return t + i;
  endfunction

  task automatic chk(input string req, input string what, input logic [79:0] act, input logic [79:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] op, input logic [2:0] idx, input logic [79:0] d,
                      input logic w, input logic [79:0] wd);
    string req;
    logic e_ovf, e_unf, e_val;
    logic [79:0] e_a, e_b, tmp;
    logic [2:0] n, b;
    e_ovf = 0; e_unf = 0; e_val = 0; e_a = '0; e_b = '0; req = "R10";
    if (w) begin
      m_mem[m_top] = wd; m_tag[m_top] = 1'b1; req = "R9";
    end else begin
      case (op)
        3'd1: begin
          n = slot(m_top, 3'd7);
          if (m_tag[n]) begin e_ovf = 1; req = "R3"; end
          else begin m_mem[n] = d; m_tag[n] = 1'b1; m_top = n; req = "R2"; end
        end
        3'd2: begin
          if (!m_tag[m_top]) begin e_unf = 1; req = "R5"; end
          else begin
            e_val = 1; e_a = m_mem[m_top]; m_tag[m_top] = 1'b0;
            m_top = slot(m_top, 3'd1); req = "R4";
          end
        end
        3'd3: begin
          b = slot(m_top, idx);
          if (!(m_tag[m_top] && m_tag[b])) begin e_unf = 1; req = "R5"; end
          else begin
            tmp = m_mem[m_top]; m_mem[m_top] = m_mem[b]; m_mem[b] = tmp; req = "R8";
          end
        end
        3'd4, 3'd5: begin
          b = (op == 3'd4) ? slot(m_top, 3'd1) : slot(m_top, idx);
          if (!(m_tag[m_top] && m_tag[b])) begin e_unf = 1; req = "R5"; end
          else begin
            e_val = 1; e_a = m_mem[m_top]; e_b = m_mem[b];
            req = (op == 3'd4) ? "R6" : "R7";
          end
        end
        default: ;
      endcase
    end
    cmd_valid = 1'b1; cmd_op = op; cmd_idx = idx; push_data = d;
    wb_en = w; wb_data = wd;
    @(negedge clk);
    chk(req, "top_o", 80'(top_o), 80'(m_top));
    chk(req, "tag_o", 80'(tag_o), 80'(m_tag));
    chk(req, "stack_overflow", 80'(stack_overflow), 80'(e_ovf));
    chk(req, "stack_underflow", 80'(stack_underflow), 80'(e_unf));
    chk(req, "out_valid", 80'(out_valid), 80'(e_val));
    if (e_val) begin
      chk(req, "opa_data", opa_data, e_a);
      if (op != 3'd2) chk(req, "opb_data", opb_data, e_b);
    end
    cmd_valid = 1'b0; wb_en = 1'b0;
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [79:0] v;
    void'($urandom(32'd4242));
    rst = 1'b1; cmd_valid = 0; cmd_op = 0; cmd_idx = 0; push_data = 0; wb_en = 0; wb_data = 0;
    m_tag = '0; m_top = '0;
    for (int k = 0; k < 8; k++) m_mem[k] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "top_o", 80'(top_o), 80'(0));
    chk("R1", "tag_o", 80'(tag_o), 80'(0));
    chk("R1", "stack_overflow", 80'(stack_overflow), 80'(0));
    chk("R1", "stack_underflow", 80'(stack_underflow), 80'(0));
    chk("R1", "out_valid", 80'(out_valid), 80'(0));

    step(3'd2, 3'd0, '0, 0, '0);              // R5 pop of empty stack
    step(3'd4, 3'd0, '0, 0, '0);              // R5 read of empty stack
    step(3'd1, 3'd0, 80'h1111, 0, '0);        // R2 push wraps top 0 -> 7
    chk("R2", "top wrap", 80'(top_o), 80'(7));
    step(3'd4, 3'd0, '0, 0, '0);              // R5 st(1) empty
    for (int k = 0; k < 7; k++) step(3'd1, 3'd0, rnd80(), 0, '0);
    step(3'd1, 3'd0, 80'hdead, 0, '0);        // R3 ninth push overflows
    step(3'd4, 3'd5, '0, 0, '0);              // R6 idx ignored
    step(3'd5, 3'd5, '0, 0, '0);              // R7
    step(3'd5, 3'd0, '0, 0, '0);              // R7 index 0
    step(3'd3, 3'd3, '0, 0, '0);              // R8
    step(3'd5, 3'd3, '0, 0, '0);              // R7 contents after swap
    step(3'd3, 3'd0, '0, 0, '0);              // R8 index 0
    step(3'd4, 3'd0, '0, 0, '0);
    v = rnd80();
    step(3'd2, 3'd0, '0, 1, v);               // R9 pop ignored during write-back
    step(3'd4, 3'd0, '0, 0, '0);              // R9 st(0) holds result
    chk("R9", "wb result", opa_data, v);
    step(3'd6, 3'd0, '0, 0, '0);              // R2 code 6 acts as no operation
    for (int k = 0; k < 8; k++) step(3'd2, 3'd0, '0, 0, '0);  // R4
    step(3'd2, 3'd0, '0, 0, '0);              // R5
    step(3'd1, 3'd0, '0, 1, 80'h77);          // R9 push ignored, write-back to empty top
    step(3'd4, 3'd0, '0, 0, '0);              // R5
    step(3'd3, 3'd2, '0, 0, '0);              // R5 exchange with empty

    for (int k = 0; k < 4000; k++) begin
      int r;
      logic [2:0] op;
      r = $urandom_range(0, 99);
      if      (r < 28) op = 3'd1;
      else if (r < 50) op = 3'd2;
      else if (r < 62) op = 3'd3;
      else if (r < 76) op = 3'd4;
      else if (r < 92) op = 3'd5;
      else             op = 3'(r % 8);
      step(op, 3'($urandom_range(0, 7)), rnd80(), ($urandom_range(0, 11) == 0), rnd80());
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule